// File: doc/BRIEF.md
# Lane Rate Frequency Band Selector

This block turns a requested per-lane data rate, in Mbps, into the settings a receive PHY needs for that rate. It returns a 7-bit high-speed band code and a 9-bit delay-line calibration value. It also returns a configuration-clock range code, computed from the configuration clock frequency in MHz. The rate table holds 63 ascending entries, from 80 Mbps to 2500 Mbps. It is computed inside the block and walked one entry per clock. The walk picks the entry nearest the request. When two entries are equally far from the request, the lower rate wins.

A request is a single valid/ready transfer. `req_ready` is high only while the block is idle, so a producer that holds `req_valid` sees back-pressure for the whole walk. Requests offered while the block is busy are not taken. The result comes back as a one-cycle pulse on `rsp_valid`. The result side has no ready input, so the consumer must capture the result in that cycle.

The parameter `MAX_MBPS` sets the highest accepted rate, 1500 or 2500. The parameter `CFG_W` sets the width of the configuration-clock code: 6 bits for the standalone PHY, 8 bits for the combined PHY.

Top module: `lane_band_sel`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle after `rsp_valid`, and is 1 again in that cycle.
- R3: A rate below 80 or above `MAX_MBPS` gives `rsp_valid` with `rsp_error`=1 one cycle after acceptance. In that case `rsp_band` and `rsp_ddl` are 0.
- R4: For an in-range rate, `rsp_error` is 0 and the chosen entry is the one with the smallest absolute rate difference. On a tie, the lower rate is chosen.
- R5: The band code of each chosen entry matches the table. Sample entries: 80→0x00, 120→0x01, 1000→0x0A, 1500→0x2C, 2000→0x0F, 2500→0x49. From 2050 upward, the code is 0x40 plus one per 50 Mbps.
- R6: The delay-line value is 489 for entries up to 1500. For entries 1550 to 2000 in 50 Mbps steps it is 303, 313, 323, 333, 342, 352, 362, 372, 381, 391. It is 401 at 2050 and 411 from 2100 up.
- R7: `rsp_cfg_code` equals (`req_cfg_mhz` − 17) × 4 modulo 2^`CFG_W`, taken from the accepted request.
- R8: For an in-range rate, `rsp_valid` rises k+2 cycles after acceptance. Here k is the number of table entries whose rate is below the request.
- R9: `rsp_valid` is high for exactly one cycle per accepted request.
- R10: A request offered while the block is busy causes no response and does not change the result of the request being processed.
- R11: With `MAX_MBPS`=1500, a rate of 1500 is served, 1501 is rejected, and the combined-PHY code width `CFG_W`=8 keeps all 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rate | input | RATE_W (12) | Requested lane rate in Mbps |
| req_cfg_mhz | input | MHZ_W (8) | Configuration clock frequency in MHz |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_error | output | 1 | Rate not supported |
| rsp_band | output | 7 | High-speed frequency band code |
| rsp_ddl | output | 9 | Delay-line calibration value |
| rsp_cfg_code | output | CFG_W (6) | Configuration clock range code |

## Verification
A walk index that skips or repeats an entry shows up in two ways. The response arrives at the wrong cycle relative to acceptance, and it can carry a neighbouring band code. Both are visible on the first request whose rate lies beyond the fault. A stale previous-entry register or a wrong tie comparison returns the upper neighbour, and this is seen on the request itself at midpoints such as 85 or 2075. A control state that fails to return to idle leaves `req_ready` low, which is caught in the cycle after the result pulse.

// File: rtl/lane_band_pkg.sv
package lane_band_pkg;
  localparam int unsigned N_ENTRIES = 63;
  localparam int unsigned IDX_W     = $clog2(N_ENTRIES);
  localparam int unsigned BAND_W    = 7;
  localparam int unsigned DDL_W     = 9;
  localparam int unsigned ENT_W     = 12;
  localparam int unsigned MIN_MBPS  = 80;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} walk_state_t;

  // Rate of entry i: four spacing segments.
  function automatic logic [ENT_W-1:0] entry_rate(int unsigned i);
    int unsigned r;
    if (i < 12)      r = 80  + 10 * i;
    else if (i < 16) r = 205 + 15 * (i - 12);
    else if (i < 20) r = 275 + 25 * (i - 16);
    else             r = 400 + 50 * (i - 20);
    return ENT_W'(r);
  endfunction

  function automatic logic [BAND_W-1:0] entry_band(int unsigned i);
    logic [7:0] b;
    case (i)
      0: b = 8'h00;  1: b = 8'h10;  2: b = 8'h20;  3: b = 8'h30;
      4: b = 8'h01;  5: b = 8'h11;  6: b = 8'h21;  7: b = 8'h31;
      8: b = 8'h02;  9: b = 8'h12; 10: b = 8'h22; 11: b = 8'h32;
     12: b = 8'h03; 13: b = 8'h13; 14: b = 8'h23; 15: b = 8'h33;
     16: b = 8'h04; 17: b = 8'h14; 18: b = 8'h25; 19: b = 8'h35;
     20: b = 8'h05; 21: b = 8'h16; 22: b = 8'h26; 23: b = 8'h37;
     24: b = 8'h07; 25: b = 8'h18; 26: b = 8'h28; 27: b = 8'h39;
     28: b = 8'h09; 29: b = 8'h19; 30: b = 8'h29; 31: b = 8'h3a;
     32: b = 8'h0a; 33: b = 8'h1a; 34: b = 8'h2a; 35: b = 8'h3b;
     36: b = 8'h0b; 37: b = 8'h1b; 38: b = 8'h2b; 39: b = 8'h3c;
     40: b = 8'h0c; 41: b = 8'h1c; 42: b = 8'h2c; 43: b = 8'h3d;
     44: b = 8'h0d; 45: b = 8'h1d; 46: b = 8'h2e; 47: b = 8'h3e;
     48: b = 8'h0e; 49: b = 8'h1e; 50: b = 8'h1f; 51: b = 8'h3f;
     52: b = 8'h0f;
      default: b = 8'(8'h40 + (i - 53));
    endcase
    return b[BAND_W-1:0];
  endfunction

  function automatic logic [DDL_W-1:0] entry_ddl(int unsigned i);
    int unsigned d;
    case (i)
      43: d = 303; 44: d = 313; 45: d = 323; 46: d = 333; 47: d = 342;
      48: d = 352; 49: d = 362; 50: d = 372; 51: d = 381; 52: d = 391;
      53: d = 401;
      default: d = (i <= 42) ? 489 : 411;
    endcase
    return DDL_W'(d);
  endfunction
endpackage

// File: rtl/lane_band_rom.sv
module lane_band_rom
  import lane_band_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [ENT_W-1:0]  ent_rate,
  output logic [BAND_W-1:0] ent_band,
  output logic [DDL_W-1:0]  ent_ddl
);
  logic [ENT_W-1:0]  tab_rate [N_ENTRIES];
  logic [BAND_W-1:0] tab_band [N_ENTRIES];
  logic [DDL_W-1:0]  tab_ddl  [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign tab_rate[g] = entry_rate(g);
    assign tab_band[g] = entry_band(g);
    assign tab_ddl[g]  = entry_ddl(g);
  end

  always_comb begin
    if (int'(idx) < N_ENTRIES) begin
      ent_rate = tab_rate[idx];
      ent_band = tab_band[idx];
      ent_ddl  = tab_ddl[idx];
    end else begin
      ent_rate = '1;
      ent_band = '0;
      ent_ddl  = '0;
    end
  end
endmodule

// File: rtl/lane_band_cfgcode.sv
module lane_band_cfgcode #(
  parameter int unsigned MHZ_W = 8,
  parameter int unsigned CFG_W = 6
) (
  input  logic [MHZ_W-1:0] mhz,
  output logic [CFG_W-1:0] code
);
  localparam int unsigned FULL_W = MHZ_W + 2;
  logic [FULL_W-1:0] full;

  always_comb begin
    full = ({2'b00, mhz} - FULL_W'(17)) << 2;
    code = full[CFG_W-1:0];
  end
endmodule

// File: rtl/lane_band_walker.sv
module lane_band_walker
  import lane_band_pkg::*;
#(
  parameter int unsigned RATE_W   = 12,
  parameter int unsigned MAX_MBPS = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [RATE_W-1:0] req_rate,
  output logic              idle,
  output logic              accept,
  output logic              done,
  output logic              err,
  output logic [BAND_W-1:0] band,
  output logic [DDL_W-1:0]  ddl
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  walk_state_t       state;
  logic [IDX_W-1:0]  idx;
  logic [RATE_W-1:0] tgt;
  logic              have_prev;
  logic [RATE_W-1:0] prev_rate;
  logic [BAND_W-1:0] prev_band;
  logic [DDL_W-1:0]  prev_ddl;
  logic [ENT_W-1:0]  ent_rate;
  logic [BAND_W-1:0] ent_band;
  logic [DDL_W-1:0]  ent_ddl;
  logic [RATE_W-1:0] cur_rate;
  logic              out_of_range;
  logic              pick_prev;

  lane_band_rom u_rom (
    .idx      (idx),
    .ent_rate (ent_rate),
    .ent_band (ent_band),
    .ent_ddl  (ent_ddl)
  );

  assign idle         = (state == ST_IDLE);
  assign done         = (state == ST_DONE);
  assign accept       = idle && req_valid;
  assign cur_rate     = RATE_W'(ent_rate);
  assign out_of_range = (req_rate < RATE_W'(MIN_MBPS)) || (req_rate > RATE_W'(MAX_MBPS));
  assign pick_prev    = have_prev && ((tgt - prev_rate) <= (cur_rate - tgt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      tgt       <= '0;
      have_prev <= 1'b0;
      prev_rate <= '0;
      prev_band <= '0;
      prev_ddl  <= '0;
      err       <= 1'b0;
      band      <= '0;
      ddl       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          tgt       <= req_rate;
          idx       <= '0;
          have_prev <= 1'b0;
          err       <= out_of_range;
          band      <= '0;
          ddl       <= '0;
          state     <= out_of_range ? ST_DONE : ST_WALK;
        end
        ST_WALK: begin
          if (cur_rate >= tgt) begin
            band  <= pick_prev ? prev_band : ent_band;
            ddl   <= pick_prev ? prev_ddl  : ent_ddl;
            state <= ST_DONE;
          end else if (idx == LAST) begin
            err   <= 1'b1;
            state <= ST_DONE;
          end else begin
            idx       <= idx + 1'b1;
            have_prev <= 1'b1;
            prev_rate <= cur_rate;
            prev_band <= ent_band;
            prev_ddl  <= ent_ddl;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_band_sel.sv
module lane_band_sel
  import lane_band_pkg::*;
#(
  parameter int unsigned RATE_W   = 12,
  parameter int unsigned MHZ_W    = 8,
  parameter int unsigned CFG_W    = 6,
  parameter int unsigned MAX_MBPS = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [MHZ_W-1:0]  req_cfg_mhz,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [6:0]        rsp_band,
  output logic [8:0]        rsp_ddl,
  output logic [CFG_W-1:0]  rsp_cfg_code
);
  logic             accept;
  logic [CFG_W-1:0] cfg_next;

  lane_band_walker #(.RATE_W(RATE_W), .MAX_MBPS(MAX_MBPS)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_rate  (req_rate),
    .idle      (req_ready),
    .accept    (accept),
    .done      (rsp_valid),
    .err       (rsp_error),
    .band      (rsp_band),
    .ddl       (rsp_ddl)
  );

  lane_band_cfgcode #(.MHZ_W(MHZ_W), .CFG_W(CFG_W)) u_cfg (
    .mhz  (req_cfg_mhz),
    .code (cfg_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rsp_cfg_code <= '0;
    else if (accept) rsp_cfg_code <= cfg_next;
  end
endmodule

// File: rtl/lane_band_sel_chk.sv
module lane_band_sel_chk #(
  parameter int unsigned RATE_W   = 12,
  parameter int unsigned MAX_MBPS = 2500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [RATE_W-1:0] req_rate,
  input logic              rsp_valid,
  input logic              rsp_error
);
  logic acc, bad;
  assign acc = req_valid && req_ready;
  assign bad = (req_rate < RATE_W'(80)) || (req_rate > RATE_W'(MAX_MBPS));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);
  a_r2_idle_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  a_r3_fast_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad) |=> (rsp_valid && rsp_error));
  a_r8_walk_not_instant: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !bad) |=> !rsp_valid);
  a_r2_no_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind lane_band_sel lane_band_sel_chk #(.RATE_W(RATE_W), .MAX_MBPS(MAX_MBPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_rate  (req_rate),
  .rsp_valid (rsp_valid),
  .rsp_error (rsp_error)
);

// File: tb/test_lane_band_sel.sv
`timescale 1ns/1ps
module test_lane_band_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // main instance: 2500 max, 6-bit code
  logic        v_a = 0;  logic [11:0] r_a = 0; logic [7:0] m_a = 0;
  logic        rdy_a, rv_a, er_a; logic [6:0] b_a; logic [8:0] d_a; logic [5:0] c_a;
  // low instance: 1500 max, 8-bit code
  logic        v_b = 0;  logic [11:0] r_b = 0; logic [7:0] m_b = 0;
  logic        rdy_b, rv_b, er_b; logic [6:0] b_b; logic [8:0] d_b; logic [7:0] c_b;

  lane_band_sel i_lane_band_sel (
    .clk(clk), .rst_n(rst_n), .req_valid(v_a), .req_ready(rdy_a), .req_rate(r_a),
    .req_cfg_mhz(m_a), .rsp_valid(rv_a), .rsp_error(er_a), .rsp_band(b_a),
    .rsp_ddl(d_a), .rsp_cfg_code(c_a));

  lane_band_sel #(.CFG_W(8), .MAX_MBPS(1500)) i_lane_band_sel_lo (
    .clk(clk), .rst_n(rst_n), .req_valid(v_b), .req_ready(rdy_b), .req_rate(r_b),
    .req_cfg_mhz(m_b), .rsp_valid(rv_b), .rsp_error(er_b), .rsp_band(b_b),
    .rsp_ddl(d_b), .rsp_cfg_code(c_b));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // band codes keyed by rate; returns 0 when the rate is not a table entry
  function automatic bit band_of(input int r, output int b);
    bit hit = 1;
    b = 0;
    case (r)
      80: b='h00; 90: b='h10; 100: b='h20; 110: b='h30; 120: b='h01; 130: b='h11;
      140: b='h21; 150: b='h31; 160: b='h02; 170: b='h12; 180: b='h22; 190: b='h32;
      205: b='h03; 220: b='h13; 235: b='h23; 250: b='h33; 275: b='h04; 300: b='h14;
      325: b='h25; 350: b='h35; 400: b='h05; 450: b='h16; 500: b='h26; 550: b='h37;
      600: b='h07; 650: b='h18; 700: b='h28; 750: b='h39; 800: b='h09; 850: b='h19;
      900: b='h29; 950: b='h3a; 1000: b='h0a; 1050: b='h1a; 1100: b='h2a; 1150: b='h3b;
      1200: b='h0b; 1250: b='h1b; 1300: b='h2b; 1350: b='h3c; 1400: b='h0c; 1450: b='h1c;
      1500: b='h2c; 1550: b='h3d; 1600: b='h0d; 1650: b='h1d; 1700: b='h2e; 1750: b='h3e;
      1800: b='h0e; 1850: b='h1e; 1900: b='h1f; 1950: b='h3f; 2000: b='h0f;
      default: begin
        if (r >= 2050 && r <= 2500 && (r % 50) == 0) b = 'h40 + (r - 2050) / 50;
        else hit = 0;
      end
    endcase
    return hit;
  endfunction

  function automatic int ddl_of(input int r);
    if (r <= 1500) return 489;
    case (r)
      1550: return 303; 1600: return 313; 1650: return 323; 1700: return 333;
      1750: return 342; 1800: return 352; 1850: return 362; 1900: return 372;
      1950: return 381; 2000: return 391; 2050: return 401;
      default: return 411;
    endcase
  endfunction

  task automatic model(input int rate, input int maxr, output bit err, output int band,
                       output int ddl, output int lat);
    int best = -1, bestd = 0, k = 0, b;
    err = 0; band = 0; ddl = 0;
    if (rate < 80 || rate > maxr) begin err = 1; lat = 1; return; end
    for (int r = 80; r <= 2500; r++) begin
      if (band_of(r, b)) begin
        int d = (r > rate) ? r - rate : rate - r;
        if (r < rate) k++;
        if (best < 0 || d < bestd) begin best = r; bestd = d; end
      end
    end
    void'(band_of(best, band));
    ddl = ddl_of(best);
    lat = k + 2;
  endtask

  task automatic run(input bit lo, input int rate, input int mhz);
    bit eerr; int eb, ed, elat, lat, ecfg, w;
    bit rv, er, rdy; int b, d, c;
    w = lo ? 8 : 6;
    model(rate, lo ? 1500 : 2500, eerr, eb, ed, elat);
    ecfg = ((mhz - 17) * 4) & ((1 << w) - 1);
    @(negedge clk);
    rdy = lo ? rdy_b : rdy_a;
    chk(rdy == 1, "R2 ready before request", rdy, 1);
    if (lo) begin v_b = 1; r_b = 12'(rate); m_b = 8'(mhz); end
    else    begin v_a = 1; r_a = 12'(rate); m_a = 8'(mhz); end
    @(negedge clk);
    v_a = 0; v_b = 0;
    lat = 1;
    rv = lo ? rv_b : rv_a;
    while (!rv && lat < 200) begin
      @(negedge clk); lat++; rv = lo ? rv_b : rv_a;
    end
    er = lo ? er_b : er_a; b = lo ? b_b : b_a; d = lo ? d_b : d_a; c = lo ? c_b : c_a;
    if (lo) chk(er == eerr, "R11 error flag low-max", er, eerr);
    else    chk(er == eerr, "R3 error flag", er, eerr);
    chk(lat == elat, "R8 latency", lat, elat);
    chk(b == eb, "R4 R5 band code", b, eb);
    chk(d == ed, "R6 delay-line value", d, ed);
    chk(c == ecfg, "R7 cfg code", c, ecfg);
    @(negedge clk);
    rv = lo ? rv_b : rv_a; rdy = lo ? rdy_b : rdy_a;
    chk(rv == 0, "R9 single pulse", rv, 0);
    chk(rdy == 1, "R2 ready after result", rdy, 1);
  endtask

  task automatic busy_test();
    bit eerr; int eb, ed, elat, seen;
    model(2500, 2500, eerr, eb, ed, elat);
    @(negedge clk);
    v_a = 1; r_a = 12'd2500; m_a = 8'd40;
    @(negedge clk);
    r_a = 12'd80; m_a = 8'd20;
    for (int i = 0; i < 5; i++) begin
      chk(rdy_a == 0, "R10 R2 busy ready low", rdy_a, 0);
      @(negedge clk);
    end
    v_a = 0;
    while (!rv_a) @(negedge clk);
    chk(b_a == eb, "R10 result kept band", b_a, eb);
    chk(c_a == ((40 - 17) * 4) % 64, "R10 result kept cfg", c_a, 92 % 64);
    seen = 0;
    @(negedge clk);
    for (int i = 0; i < 70; i++) begin
      if (rv_a) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R10 ignored request gives no result", seen, 0);
  endtask

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdy_a == 1, "R1 ready after reset", rdy_a, 1);
    chk(rv_a == 0, "R1 no result after reset", rv_a, 0);
    // directed corners
    run(0, 79, 24);   run(0, 80, 24);   run(0, 85, 24);   run(0, 86, 24);
    run(0, 120, 30);  run(0, 197, 30);  run(0, 198, 30);  run(0, 1000, 33);
    run(0, 1525, 50); run(0, 2000, 50); run(0, 2075, 50); run(0, 2076, 50);
    run(0, 2500, 17); run(0, 2501, 17); run(0, 0, 17);
    run(1, 1500, 80); run(1, 1501, 80); run(1, 79, 33); run(1, 1460, 33);
    busy_test();
    for (int i = 0; i < 150; i++)
      run(i[0], int'($urandom_range(60, 2600)), int'($urandom_range(17, 80)));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule